// File: doc/BRIEF.md
# Packed Exponent Extraction Unit

This block takes a vector of up to eight 64-bit double-precision lanes. For each lane it produces the exponent of the lane's value, floor(log2|x|), written as a double-precision number. Zero, denormal, infinite and NaN inputs each get their own result. Three controls choose which lanes are written: a vector-length code, a per-lane write-enable mask, and a masking policy that either keeps the previous destination lane or clears it. A broadcast option feeds the lowest source element to every lane.

An execution pipeline uses the block as a single registered stage. Operands arrive with `in_valid`. One clock later the full 512-bit destination appears with `out_valid`. Two sticky-free exception bits come with it: invalid and denormal. Each is the OR over the lanes that were actually computed.

Top module: `vexp_pack_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following edge leaves `out_valid` low, `dst_vec` all zero and both flags low.
- R2: `out_valid` equals `in_valid` delayed by one clock. `dst_vec` and the flags load only on an edge where `in_valid` is high, and otherwise keep their value.
- R3: `vec_len` encodes the active lane count: 0 gives 2 lanes, 1 gives 4 lanes, and 2 or 3 give 8 lanes. Lane j occupies bits [64j+63:64j]. Every bit at or above 64 times the lane count is written as zero.
- R4: Some lanes hold a normal value, meaning a biased exponent field (bits [62:52]) that is neither all-zero nor all-one. Such a lane yields the exact double of (field - 1023), regardless of sign. A result of zero is written as +0.0 (all bits zero).
- R5: Some lanes hold a denormal: field zero, fraction (bits [51:0]) nonzero, and `daz` low. Such a lane yields the double of (-1023 - z), where z is the number of leading zeros of the 52-bit fraction. The lane also raises the denormal flag.
- R6: A lane with field zero and either a zero fraction or `daz` high yields -infinity (0xFFF0000000000000). It raises no flag.
- R7: A lane holding infinity of either sign yields +infinity (0x7FF0000000000000).
- R8: A lane holding a NaN yields the same bits with bit 51 forced to one. If bit 51 was zero (signaling), the lane raises the invalid flag.
- R9: With `use_mask` low, every lane inside the vector length is computed, whatever `lane_mask` and `zero_mode` hold.
- R10: With `use_mask` high, an in-range lane whose `lane_mask` bit is clear is not computed. It takes the matching `old_dst` lane when `zero_mode` is low, and zero when `zero_mode` is high.
- R11: When `bcast` and `src_is_mem` are both high, every lane uses `src_vec[63:0]` as its source. `bcast` with `src_is_mem` low has no effect.
- R12: `flag_invalid` and `flag_denormal` are the OR of the lane flags over computed lanes only. Lanes that are masked off or above the vector length contribute nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands are presented this cycle |
| vec_len | input | 2 | Vector length code (2/4/8 lanes) |
| use_mask | input | 1 | Apply `lane_mask` as per-lane write enables |
| zero_mode | input | 1 | Masked-off lanes are cleared (1) or merged (0) |
| bcast | input | 1 | Broadcast request |
| src_is_mem | input | 1 | Source operand came from memory |
| daz | input | 1 | Treat denormal inputs as zero |
| lane_mask | input | 8 | Per-lane write enables |
| src_vec | input | 512 | Source lanes |
| old_dst | input | 512 | Previous destination value for merging |
| out_valid | output | 1 | Registered result is valid |
| dst_vec | output | 512 | New destination vector |
| flag_invalid | output | 1 | A computed lane held a signaling NaN |
| flag_denormal | output | 1 | A computed lane held a denormal |

## Verification
The hardest case to reach from the ports is a flag-raising value sitting in a lane that is not computed. The flag must stay low, while the lane's data is simultaneously merged, zeroed or truncated by the vector length. The stimulus places a signaling NaN above the active length and a denormal in a masked-off lane. It then widens the mask and the length step by step, so the same operands switch each flag on in turn. Broadcast of a signaling NaN from lane 0 checks that one source element drives every lane's result and the shared flag.

// File: rtl/vxp_pkg.sv
// Package vxp_pkg
// Shared sizes and types for the packed exponent-extraction unit.
// Assumes IEEE-754 binary64 lanes and a maximum vector of eight lanes.
package vxp_pkg;
    parameter int LANE_W    = 64;
    parameter int MAX_LANES = 8;
    parameter int MIN_LANES = 2;
    parameter int VL_W      = 2;
    parameter int EXP_W     = 11;
    parameter int FRAC_W    = 52;
    parameter int BIAS      = 1023;
    localparam int DST_W    = LANE_W * MAX_LANES;
    // signed unbiased exponent needs room for -(BIAS + FRAC_W - 1)
    localparam int INT_W    = EXP_W + 2;
    // magnitude of the unbiased exponent fits in EXP_W bits
    localparam int MAG_W    = EXP_W;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_DENORM,
        CLS_NORMAL,
        CLS_INF,
        CLS_NAN
    } lane_class_e;

    // Number of active lanes for a vector length code, capped at MAX_LANES.
    function automatic int lanes_for(input logic [VL_W-1:0] code);
        int n;
        n = MIN_LANES << code;
        if (n > MAX_LANES) n = MAX_LANES;
        return n;
    endfunction
endpackage

// File: rtl/vxp_lzc.sv
// Module vxp_lzc
// Counts leading zeros of a W-bit vector (MSB first); returns W for zero.
// Purely combinational; assumes W >= 1.
module vxp_lzc #(
    parameter  int W  = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // Scan upward so the highest set bit wins.
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/vxp_getexp_lane.sv
// Module vxp_getexp_lane
// Computes floor(log2|x|) of one binary64 operand as a binary64 value,
// with the zero, denormal, infinity and NaN special cases and the two
// per-lane exception indications. Combinational; the result is exact
// because the integer exponent always fits the 52-bit fraction.
module vxp_getexp_lane
    import vxp_pkg::*;
(
    input  logic [LANE_W-1:0] operand,
    input  logic              daz,
    output logic [LANE_W-1:0] result,
    output logic              sig_invalid,
    output logic              sig_denorm
);
    localparam int LZ_FW = $clog2(FRAC_W + 1);
    localparam int LZ_MW = $clog2(MAG_W + 1);
    localparam int PAD_W = FRAC_W - (MAG_W - 1);

    logic [EXP_W-1:0]  expf;
    logic [FRAC_W-1:0] frac;
    lane_class_e       cls;
    logic [LZ_FW-1:0]  frac_lz;
    logic [INT_W-1:0]  unb;
    logic              neg;
    logic [MAG_W-1:0]  mag;
    logic [LZ_MW-1:0]  mag_lz;
    logic [MAG_W-2:0]  mag_norm;
    logic [EXP_W-1:0]  res_exp;
    logic [FRAC_W-1:0] res_frac;

    assign expf = operand[LANE_W-2:FRAC_W];
    assign frac = operand[FRAC_W-1:0];

    // Sort the operand into one of five classes.
    always_comb begin
        if (expf == '1)
            cls = (frac == '0) ? CLS_INF : CLS_NAN;
        else if (expf == '0)
            cls = ((frac == '0) || daz) ? CLS_ZERO : CLS_DENORM;
        else
            cls = CLS_NORMAL;
    end

    vxp_lzc #(.W(FRAC_W)) u_frac_lz (.vec(frac), .cnt(frac_lz));

    // Unbiased exponent as a two's-complement integer.
    always_comb begin
        if (cls == CLS_DENORM)
            unb = INT_W'(0) - INT_W'(BIAS) - INT_W'(frac_lz);
        else
            unb = INT_W'(expf) - INT_W'(BIAS);
    end

    assign neg = unb[INT_W-1];
    assign mag = MAG_W'(neg ? (INT_W'(0) - unb) : unb);

    vxp_lzc #(.W(MAG_W)) u_mag_lz (.vec(mag), .cnt(mag_lz));

    // Normalise the integer magnitude into exponent and fraction fields.
    always_comb begin
        mag_norm = (MAG_W-1)'(mag << mag_lz);
        res_exp  = EXP_W'(BIAS + MAG_W - 1) - EXP_W'(mag_lz);
        res_frac = {mag_norm, {PAD_W{1'b0}}};
    end

    // Choose the lane result and exception indications by class.
    always_comb begin
        sig_invalid = 1'b0;
        sig_denorm  = (cls == CLS_DENORM);
        unique case (cls)
            CLS_NAN: begin
                result      = {operand[LANE_W-1:FRAC_W], 1'b1, operand[FRAC_W-2:0]};
                sig_invalid = ~operand[FRAC_W-1];
            end
            CLS_INF:  result = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            CLS_ZERO: result = {1'b1, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            default: begin
                if (mag == '0) result = '0;
                else           result = {neg, res_exp, res_frac};
            end
        endcase
    end
endmodule

// File: rtl/vxp_lane_mask.sv
// Module vxp_lane_mask
// Decides for one lane position whether it lies inside the vector length
// and whether it is computed, then picks the lane's next destination:
// computed result, preserved old value, or zero. Combinational.
module vxp_lane_mask
    import vxp_pkg::*;
#(
    parameter int LANE_IDX = 0
) (
    input  logic [VL_W-1:0]   vec_len,
    input  logic              use_mask,
    input  logic              zero_mode,
    input  logic              mask_bit,
    input  logic [LANE_W-1:0] lane_result,
    input  logic [LANE_W-1:0] lane_old,
    output logic              compute,
    output logic [LANE_W-1:0] lane_next
);
    logic in_range;

    // Lane is active when below the lane count and enabled (or unmasked).
    always_comb begin
        in_range = (LANE_IDX < lanes_for(vec_len));
        compute  = in_range && (!use_mask || mask_bit);
    end

    // Select the lane's next destination content.
    always_comb begin
        if (!in_range)     lane_next = '0;
        else if (compute)  lane_next = lane_result;
        else if (zero_mode) lane_next = '0;
        else               lane_next = lane_old;
    end
endmodule

// File: rtl/vexp_pack_unit.sv
// Module vexp_pack_unit
// Top of the packed exponent-extraction unit: one extractor and one
// masking slice per lane, optional broadcast of lane 0, and a single
// output register stage with a valid bit. Assumes in_valid-qualified
// operands; the output holds between valid inputs.
module vexp_pack_unit
    import vxp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [VL_W-1:0]      vec_len,
    input  logic                 use_mask,
    input  logic                 zero_mode,
    input  logic                 bcast,
    input  logic                 src_is_mem,
    input  logic                 daz,
    input  logic [MAX_LANES-1:0] lane_mask,
    input  logic [DST_W-1:0]     src_vec,
    input  logic [DST_W-1:0]     old_dst,
    output logic                 out_valid,
    output logic [DST_W-1:0]     dst_vec,
    output logic                 flag_invalid,
    output logic                 flag_denormal
);
    logic                 bcast_on;
    logic [DST_W-1:0]     next_dst;
    logic [MAX_LANES-1:0] inv_v;
    logic [MAX_LANES-1:0] den_v;
    logic [MAX_LANES-1:0] comp_v;

    assign bcast_on = bcast && src_is_mem;

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
        logic [LANE_W-1:0] lane_src;
        logic [LANE_W-1:0] lane_res;

        assign lane_src = bcast_on ? src_vec[LANE_W-1:0]
                                   : src_vec[j*LANE_W +: LANE_W];

        vxp_getexp_lane u_getexp (
            .operand     (lane_src),
            .daz         (daz),
            .result      (lane_res),
            .sig_invalid (inv_v[j]),
            .sig_denorm  (den_v[j])
        );

        vxp_lane_mask #(.LANE_IDX(j)) u_mask (
            .vec_len     (vec_len),
            .use_mask    (use_mask),
            .zero_mode   (zero_mode),
            .mask_bit    (lane_mask[j]),
            .lane_result (lane_res),
            .lane_old    (old_dst[j*LANE_W +: LANE_W]),
            .compute     (comp_v[j]),
            .lane_next   (next_dst[j*LANE_W +: LANE_W])
        );
    end

    // Output stage: capture the vector and combined flags on valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            dst_vec       <= '0;
            flag_invalid  <= 1'b0;
            flag_denormal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst_vec       <= next_dst;
                flag_invalid  <= |(inv_v & comp_v);
                flag_denormal <= |(den_v & comp_v);
            end
        end
    end
endmodule

// File: rtl/vxp_unit_chk.sv
// Module vxp_unit_chk
// Port-level properties of vexp_pack_unit, bound to every instance.
module vxp_unit_chk
    import vxp_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [VL_W-1:0]      vec_len,
    input logic                 use_mask,
    input logic                 zero_mode,
    input logic                 bcast,
    input logic                 src_is_mem,
    input logic [MAX_LANES-1:0] lane_mask,
    input logic [DST_W-1:0]     src_vec,
    input logic [DST_W-1:0]     old_dst,
    input logic                 out_valid,
    input logic [DST_W-1:0]     dst_vec,
    input logic                 flag_invalid,
    input logic                 flag_denormal
);
    localparam logic [LANE_W-1:0] POS_INF = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && dst_vec == '0 && !flag_invalid && !flag_denormal)); // R1

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dst_vec) && $stable(flag_invalid) && $stable(flag_denormal))); // R2

    AST_TWO_LANE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vec_len == 2'd0) |=> (dst_vec[DST_W-1:2*LANE_W] == '0)); // R3

    AST_FOUR_LANE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vec_len == 2'd1) |=> (dst_vec[DST_W-1:4*LANE_W] == '0)); // R3

    AST_INF_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !use_mask && src_vec[LANE_W-2:0] == POS_INF[LANE_W-2:0])
        |=> (dst_vec[LANE_W-1:0] == POS_INF)); // R7

    AST_NO_FLAG_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && use_mask && lane_mask == '0) |=> (!flag_invalid && !flag_denormal)); // R12

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane_chk
        AST_MERGE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && use_mask && !zero_mode && !lane_mask[j] && (j < (2 << vec_len)))
            |=> (dst_vec[j*LANE_W +: LANE_W] == $past(old_dst[j*LANE_W +: LANE_W]))); // R10

        AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && use_mask && zero_mode && !lane_mask[j])
            |=> (dst_vec[j*LANE_W +: LANE_W] == '0)); // R10
    end

    // Lane 1 and lane 0 must match whenever broadcast applies and both compute.
    AST_BCAST_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bcast && src_is_mem && !use_mask)
        |=> (dst_vec[2*LANE_W-1:LANE_W] == dst_vec[LANE_W-1:0])); // R11
endmodule

bind vexp_pack_unit vxp_unit_chk u_vxp_unit_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .vec_len       (vec_len),
    .use_mask      (use_mask),
    .zero_mode     (zero_mode),
    .bcast         (bcast),
    .src_is_mem    (src_is_mem),
    .lane_mask     (lane_mask),
    .src_vec       (src_vec),
    .old_dst       (old_dst),
    .out_valid     (out_valid),
    .dst_vec       (dst_vec),
    .flag_invalid  (flag_invalid),
    .flag_denormal (flag_denormal)
);

// File: tb/test_vexp_pack_unit.sv
// Testbench for vexp_pack_unit: a per-lane value table, then directed
// tests of length, masking, broadcast, flag gating and idle hold.
module test_vexp_pack_unit;
    import vxp_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [VL_W-1:0]      vec_len = '0;
    logic                 use_mask = 1'b0;
    logic                 zero_mode = 1'b0;
    logic                 bcast = 1'b0;
    logic                 src_is_mem = 1'b0;
    logic                 daz = 1'b0;
    logic [MAX_LANES-1:0] lane_mask = '0;
    logic [DST_W-1:0]     src_vec = '0;
    logic [DST_W-1:0]     old_dst = '0;
    logic                 out_valid;
    logic [DST_W-1:0]     dst_vec;
    logic                 flag_invalid;
    logic                 flag_denormal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vexp_pack_unit i_vexp_pack_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vec_len(vec_len),
        .use_mask(use_mask), .zero_mode(zero_mode), .bcast(bcast),
        .src_is_mem(src_is_mem), .daz(daz), .lane_mask(lane_mask),
        .src_vec(src_vec), .old_dst(old_dst), .out_valid(out_valid),
        .dst_vec(dst_vec), .flag_invalid(flag_invalid), .flag_denormal(flag_denormal)
    );

    // {source[130:67], daz[66], expected[65:2], invalid[1], denormal[0]}
    localparam logic [130:0] VEC_TBL [16] = '{
        {64'h3FF0000000000000, 1'b0, 64'h0000000000000000, 1'b0, 1'b0},
        {64'h4000000000000000, 1'b0, 64'h3FF0000000000000, 1'b0, 1'b0},
        {64'h4098000000000000, 1'b0, 64'h4024000000000000, 1'b0, 1'b0},
        {64'h3FE0000000000000, 1'b0, 64'hBFF0000000000000, 1'b0, 1'b0},
        {64'hC020000000000000, 1'b0, 64'h4008000000000000, 1'b0, 1'b0},
        {64'h7FEFFFFFFFFFFFFF, 1'b0, 64'h408FF80000000000, 1'b0, 1'b0},
        {64'h0010000000000000, 1'b0, 64'hC08FF00000000000, 1'b0, 1'b0},
        {64'h0008000000000000, 1'b0, 64'hC08FF80000000000, 1'b0, 1'b1},
        {64'h0000000000000001, 1'b0, 64'hC090C80000000000, 1'b0, 1'b1},
        {64'h0000000000000001, 1'b1, 64'hFFF0000000000000, 1'b0, 1'b0},
        {64'h0000000000000000, 1'b0, 64'hFFF0000000000000, 1'b0, 1'b0},
        {64'h8000000000000000, 1'b0, 64'hFFF0000000000000, 1'b0, 1'b0},
        {64'h7FF0000000000000, 1'b0, 64'h7FF0000000000000, 1'b0, 1'b0},
        {64'hFFF0000000000000, 1'b0, 64'h7FF0000000000000, 1'b0, 1'b0},
        {64'h7FF0000000000001, 1'b0, 64'h7FF8000000000001, 1'b1, 1'b0},
        {64'hFFF8000000000ABC, 1'b0, 64'hFFF8000000000ABC, 1'b0, 1'b0}
    };

    localparam logic [63:0] ONE_D   = 64'h3FF0000000000000;
    localparam logic [63:0] TWO_D   = 64'h4000000000000000;
    localparam logic [63:0] EIGHT_D = 64'h4020000000000000;
    localparam logic [63:0] SNAN_D  = 64'h7FF0000000000001;
    localparam logic [63:0] DENRM_D = 64'h0008000000000000;

    // Double of small positive integer k (1..8).
    function automatic logic [63:0] small_int_d(input int k);
        case (k)
            1: return {16'h3FF0, 48'h0};
            2: return {16'h4000, 48'h0};
            3: return {16'h4008, 48'h0};
            4: return {16'h4010, 48'h0};
            5: return {16'h4014, 48'h0};
            6: return {16'h4018, 48'h0};
            7: return {16'h401C, 48'h0};
            default: return {16'h4020, 48'h0};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [DST_W-1:0] act,
                       input logic [DST_W-1:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // Present operands for one edge; return at the next falling edge.
    task automatic fire();
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [DST_W-1:0] exp_v;
        logic [7:0]       mval;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 reset out_valid", DST_W'(out_valid), '0);
        chk("R1 reset dst", dst_vec, '0);
        chk("R1 reset flags", DST_W'({flag_invalid, flag_denormal}), '0);
        rst_n = 1'b1;

        // Per-lane value table: lane 0 carries the case, lane 1 holds 1.0
        for (int i = 0; i < 16; i++) begin
            string tag;
            if (i < 7)       tag = "R4";
            else if (i < 9)  tag = "R5";
            else if (i < 12) tag = "R6";
            else if (i < 14) tag = "R7";
            else             tag = "R8";
            vec_len = 2'd0; use_mask = 1'b0;
            src_vec = '0;
            src_vec[63:0]   = VEC_TBL[i][130:67];
            src_vec[127:64] = ONE_D;
            daz = VEC_TBL[i][66];
            fire();
            chk($sformatf("%s table %0d dst", tag, i), dst_vec,
                {448'h0, 64'h0, VEC_TBL[i][65:2]});
            chk($sformatf("%s table %0d flags", tag, i),
                DST_W'({flag_invalid, flag_denormal}), DST_W'(VEC_TBL[i][1:0]));
        end
        daz = 1'b0;

        // R3/R9: vector length sweep, mask ignored while masking disabled
        for (int v = 0; v < 4; v++) begin
            int n;
            n = (v == 0) ? 2 : (v == 1) ? 4 : 8;
            vec_len = VL_W'(v); use_mask = 1'b0; zero_mode = 1'b1; lane_mask = '0;
            src_vec = {8{TWO_D}};
            old_dst = {8{64'hA5A5_5A5A_A5A5_5A5A}};
            exp_v = '0;
            for (int j = 0; j < n; j++) exp_v[j*64 +: 64] = ONE_D;
            fire();
            chk($sformatf("R3 R9 vec_len=%0d", v), dst_vec, exp_v);
            chk("R2 out_valid after input", DST_W'(out_valid), DST_W'(1));
        end

        // R10: merge masking
        mval = 8'b1010_0101;
        vec_len = 2'd2; use_mask = 1'b1; zero_mode = 1'b0; lane_mask = mval;
        for (int j = 0; j < 8; j++) begin
            src_vec[j*64 +: 64] = {1'b0, 11'(1024 + j), 52'h0};
            old_dst[j*64 +: 64] = 64'hDEAD_0000_0000_0000 | 64'(j);
        end
        exp_v = '0;
        for (int j = 0; j < 8; j++)
            exp_v[j*64 +: 64] = mval[j] ? small_int_d(j + 1) : old_dst[j*64 +: 64];
        fire();
        chk("R10 merge keeps old lanes", dst_vec, exp_v);

        // R10: zeroing masking
        zero_mode = 1'b1;
        for (int j = 0; j < 8; j++)
            exp_v[j*64 +: 64] = mval[j] ? small_int_d(j + 1) : 64'h0;
        fire();
        chk("R10 zeroing clears lanes", dst_vec, exp_v);

        // R9: masking disabled computes all lanes despite mask and zero_mode
        use_mask = 1'b0;
        for (int j = 0; j < 8; j++) exp_v[j*64 +: 64] = small_int_d(j + 1);
        fire();
        chk("R9 unmasked all lanes", dst_vec, exp_v);

        // R11: broadcast with memory source uses lane 0 everywhere
        src_vec = {8{TWO_D}};
        src_vec[63:0] = EIGHT_D;
        bcast = 1'b1; src_is_mem = 1'b1;
        fire();
        chk("R11 broadcast from lane 0", dst_vec, {8{small_int_d(3)}});

        // R11: broadcast without memory source has no effect
        src_is_mem = 1'b0;
        exp_v = {{7{ONE_D}}, small_int_d(3)};
        fire();
        chk("R11 broadcast ignored for register source", dst_vec, exp_v);
        bcast = 1'b0;

        // R12: flags from lanes not computed are excluded
        src_vec = {8{ONE_D}};
        src_vec[2*64 +: 64] = SNAN_D;
        src_vec[1*64 +: 64] = DENRM_D;
        vec_len = 2'd0; use_mask = 1'b1; zero_mode = 1'b0; lane_mask = 8'b0000_0001;
        old_dst = '0;
        fire();
        chk("R12 masked and out-of-range flags", DST_W'({flag_invalid, flag_denormal}), '0);
        lane_mask = 8'b0000_0011;
        fire();
        chk("R12 denormal lane enabled", DST_W'({flag_invalid, flag_denormal}), DST_W'(2'b01));
        vec_len = 2'd1;
        lane_mask = 8'b0000_0101;
        fire();
        chk("R12 SNaN lane in range", DST_W'({flag_invalid, flag_denormal}), DST_W'(2'b10));

        // R11/R8: broadcast of a signaling NaN
        use_mask = 1'b0; bcast = 1'b1; src_is_mem = 1'b1;
        src_vec[63:0] = SNAN_D;
        fire();
        chk("R11 broadcast SNaN data", dst_vec, {256'h0, {4{64'h7FF8000000000001}}});
        chk("R8 broadcast SNaN flag", DST_W'({flag_invalid, flag_denormal}), DST_W'(2'b10));
        bcast = 1'b0; src_is_mem = 1'b0;

        // R2: idle cycle keeps the output and drops out_valid
        exp_v = dst_vec;
        src_vec = {8{EIGHT_D}};
        @(posedge clk);
        @(negedge clk);
        chk("R2 idle out_valid low", DST_W'(out_valid), '0);
        chk("R2 idle dst held", dst_vec, exp_v);
        chk("R2 idle flags held", DST_W'({flag_invalid, flag_denormal}), DST_W'(2'b10));

        finish_run();
    end
endmodule